// File: doc/BRIEF.md
# Calendar Real-Time Clock Core

This core keeps wall-clock time and date for a chip that has a slow 32.768 kHz timebase. The timebase reaches the core as a one-cycle enable pulse in the system clock domain. A prescaler counts these pulses to make a one-second tick. A chain of BCD counters then advances seconds, minutes, hours, weekday, date, month, year and century. The chain knows the length of each month and the leap-year rule, and it counts hours in either a 24-hour or a 12-hour AM/PM format.

Software reaches the core through a byte-wide register port. A write updates one live register. It also restarts the sub-second count, so the next tick arrives one full second after the write. A read-start strobe copies all eight live registers into a holding copy and sets a read pointer. Later read-next strobes step through the holding copy. A multi-byte read therefore always returns one consistent time, even when a rollover happens partway through.

After a cold reset the clock stands still and reports itself halted. It starts counting only after software writes any clock register.

Top module: `rtc_calendar_core`

## Requirements
- R1: With the clock running, the time advances by one second for every DIV enable pulses. The first advance comes on the DIV-th pulse after the most recent register write.
- R2: Register map: address 0 is seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 7 century. All fields are packed BCD. Seconds and minutes count 00 to 59, and each 59 to 00 rollover carries into the next field.
- R3: Bit 7 of the hour register set to 1 selects 24-hour mode. In this mode hours 00 to 23 sit in bits 5:0, and 23 to 00 advances the day.
- R4: Bit 7 of the hour register at 0 selects 12-hour mode. Hours 01 to 12 sit in bits 4:0 and bit 5 is the PM flag. 11 AM goes to 12 PM, 11 PM goes to 12 AM of the next day, and 12 goes to 01 with no change to the flag.
- R5: The date goes from 30 to 01 in April, June, September and November, and from 31 to 01 in the other months except February. Each such wrap advances the month, and December wraps to January.
- R6: In February the date wraps after 29 in a leap year and after 28 otherwise. A year whose value mod 4 is 0 is a leap year.
- R7: Year 99 rolls to 00 and increments the century. Year 00 is a leap year only when the century mod 4 is 0.
- R8: The weekday counts 0 to 6, wraps from 6 to 0, and advances on the same tick as the date.
- R9: After reset the registers hold 00 s, 00 min, hour 0x80, weekday 0, date 01, month 01, year 00 and century 20, and `halted` is 1. No time field changes until the first register write, and that write clears `halted`.
- R10: A write that lands on the same cycle as a second tick takes priority. The written value is kept, that tick is lost, and the next advance comes DIV pulses later.
- R11: A read-start strobe captures all fields into the holding copy and points `rd_data` at `reg_addr`. Each read-next strobe advances the pointer, wrapping from 7 to 0. A rollover on the same edge as the capture does not change the captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per 32.768 kHz timebase period |
| reg_addr | input | 3 | Register address for writes and for the read start |
| wr_en | input | 1 | Write strobe for the live register at `reg_addr` |
| wr_data | input | 8 | Write data |
| rd_start | input | 1 | Capture the time and set the read pointer to `reg_addr` |
| rd_next | input | 1 | Advance the read pointer by one |
| rd_data | output | 8 | Byte of the holding copy at the read pointer |
| halted | output | 1 | High from reset until the first register write |

## Verification
A software write and a second tick can fall on the same clock edge. A capture strobe and a rollover can also coincide. The bench provokes both by letting exactly DIV-1 enable pulses pass after a write. On the next edge, where the tick is due, it raises the enable together with a write or with a read start. It judges the write collision by seeing the written seconds value unchanged after DIV-1 more pulses and advanced after one more. It judges the capture collision by reading the old 23:59:59 time back from the holding copy while a fresh capture shows the new day.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int NUM_REGS = 8;
   localparam int ADDR_W   = $clog2(NUM_REGS);

   // field order: the last member sits at the lowest byte, so byte i is address i
   typedef struct packed {
      logic [7:0] cent;
      logic [7:0] year;
      logic [7:0] month;
      logic [7:0] date;
      logic [7:0] dow;
      logic [7:0] hour;
      logic [7:0] min;
      logic [7:0] sec;
   } rtc_time_t;

   localparam rtc_time_t RTC_RESET = '{cent: 8'h20, year: 8'h00, month: 8'h01,
                                       date: 8'h01, dow: 8'h00, hour: 8'h80,
                                       min: 8'h00, sec: 8'h00};

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return v + 8'd1;
   endfunction

   function automatic int bcd_to_int(input logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   function automatic logic leap_year(input logic [7:0] year, input logic [7:0] cent);
      if (year == 8'h00) return (bcd_to_int(cent) % 4) == 0;
      return (bcd_to_int(year) % 4) == 0;
   endfunction

   function automatic logic [7:0] month_last_day(input logic [7:0] month,
                                                 input logic [7:0] year,
                                                 input logic [7:0] cent);
      case (month)
         8'h02:                      return leap_year(year, cent) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic en,
   input  logic clear,
   output logic sec_tick
);
   localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

   if (DIV < 2) begin : g_bad_div
      $error("rtc_prescaler: DIV must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic             at_last;

   // a power-of-two divider wraps by itself; others need a terminal compare
   if ((DIV & (DIV - 1)) == 0) begin : g_pow2
      assign at_last = &cnt;
   end else begin : g_cmp
      assign at_last = (cnt == CNT_W'(DIV - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (clear || !run)  cnt <= '0;
      else if (en)             cnt <= at_last ? '0 : cnt + 1'b1;
   end

   assign sec_tick = run && en && at_last && !clear;

   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) < DIV);

   // R10
   wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt == '0) && !sec_tick);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output rtc_time_t         now,
   output logic              running
);
   rtc_time_t                    nx;
   rtc_time_t                    merged;
   logic [NUM_REGS-1:0][7:0]     bytes_w;
   logic                         c_min, c_hr, c_day, c_mon, c_yr, c_cent;
   logic [7:0]                   hinc24, hinc12;

   always_comb begin
      bytes_w          = now;
      bytes_w[wr_addr] = wr_data;
      merged           = rtc_time_t'(bytes_w);
   end

   always_comb begin
      nx     = now;
      c_min  = 1'b0; c_hr = 1'b0; c_day = 1'b0;
      c_mon  = 1'b0; c_yr = 1'b0; c_cent = 1'b0;
      hinc24 = bcd_inc({2'b00, now.hour[5:0]});
      hinc12 = bcd_inc({3'b000, now.hour[4:0]});

      if (now.sec == 8'h59) begin nx.sec = 8'h00; c_min = 1'b1; end
      else                         nx.sec = bcd_inc(now.sec);

      if (c_min) begin
         if (now.min == 8'h59) begin nx.min = 8'h00; c_hr = 1'b1; end
         else                         nx.min = bcd_inc(now.min);
      end

      if (c_hr) begin
         if (now.hour[7]) begin
            if (now.hour[5:0] == 6'h23) begin nx.hour = 8'h80; c_day = 1'b1; end
            else                               nx.hour = {2'b10, hinc24[5:0]};
         end else begin
            if (now.hour[4:0] == 5'h12)
               nx.hour = {2'b00, now.hour[5], 5'h01};
            else if (now.hour[4:0] == 5'h11) begin
               nx.hour = {2'b00, ~now.hour[5], 5'h12};
               c_day   = now.hour[5];
            end else
               nx.hour = {2'b00, now.hour[5], hinc12[4:0]};
         end
      end

      if (c_day) begin
         nx.dow = (now.dow >= 8'd6) ? 8'd0 : now.dow + 8'd1;
         if (now.date == month_last_day(now.month, now.year, now.cent)) begin
            nx.date = 8'h01; c_mon = 1'b1;
         end else nx.date = bcd_inc(now.date);
      end

      if (c_mon) begin
         if (now.month == 8'h12) begin nx.month = 8'h01; c_yr = 1'b1; end
         else                           nx.month = bcd_inc(now.month);
      end

      if (c_yr) begin
         if (now.year == 8'h99) begin nx.year = 8'h00; c_cent = 1'b1; end
         else                          nx.year = bcd_inc(now.year);
      end

      if (c_cent) nx.cent = (now.cent == 8'h99) ? 8'h00 : bcd_inc(now.cent);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         now     <= RTC_RESET;
         running <= 1'b0;
      end else begin
         if (wr_en)         now <= merged;
         else if (sec_tick) now <= nx;
         if (wr_en) running <= 1'b1;
      end
   end

   // R9
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !wr_en) |=> $stable(now));

   // R2
   sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !wr_en && now.sec == 8'h59) |=> (now.sec == 8'h00));

endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
   import rtc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_start,
   input  logic              rd_next,
   input  logic [ADDR_W-1:0] rd_addr,
   input  rtc_time_t         live,
   output logic [7:0]        rd_data
);
   rtc_time_t                snap;
   logic [NUM_REGS-1:0][7:0] snap_b;
   logic [ADDR_W-1:0]        ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap <= RTC_RESET;
         ptr  <= '0;
      end else if (rd_start) begin
         snap <= live;
         ptr  <= rd_addr;
      end else if (rd_next) begin
         ptr  <= ptr + 1'b1;
      end
   end

   assign snap_b  = snap;
   assign rd_data = snap_b[ptr];

   // R11
   snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |=> (snap == $past(live)));

   // R11
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_start |=> $stable(snap));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_pkg::*;
#(
   parameter int DIV = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   input  logic              rd_start,
   input  logic              rd_next,
   output logic [7:0]        rd_data,
   output logic              halted
);
   logic      sec_tick;
   logic      running;
   rtc_time_t live;

   rtc_prescaler #(.DIV(DIV)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (running),
      .en       (tick_en),
      .clear    (wr_en),
      .sec_tick (sec_tick)
   );

   rtc_calendar u_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .wr_en    (wr_en),
      .wr_addr  (reg_addr),
      .wr_data  (wr_data),
      .now      (live),
      .running  (running)
   );

   rtc_snapshot u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_start (rd_start),
      .rd_next  (rd_next),
      .rd_addr  (reg_addr),
      .live     (live),
      .rd_data  (rd_data)
   );

   assign halted = !running;

endmodule

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb_top;
   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_start = 1'b0;
   logic       rd_next = 1'b0;
   logic [7:0] rd_data;
   logic       halted;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   // reference model, plain integers
   int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_cent;
   bit m_24;

   always #2 clk = ~clk;

   rtc_calendar_core #(.DIV(DIV)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
      .wr_en(wr_en), .wr_data(wr_data), .rd_start(rd_start), .rd_next(rd_next),
      .rd_data(rd_data), .halted(halted)
   );

   function automatic logic [7:0] to_bcd(input int n);
      return 8'((n / 10) * 16 + (n % 10));
   endfunction

   function automatic int days_of(input int mo, input int y, input int c);
      bit lp;
      lp = (y == 0) ? (c % 4 == 0) : (y % 4 == 0);
      if (mo == 2) return lp ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] hour_byte(input int h, input bit f24);
      int h12;
      if (f24) return 8'h80 | to_bcd(h);
      h12 = (h % 12 == 0) ? 12 : h % 12;
      return to_bcd(h12) | ((h >= 12) ? 8'h20 : 8'h00);
   endfunction

   function automatic logic [7:0] exp_byte(input int a);
      case (a)
         0: return to_bcd(m_sec);
         1: return to_bcd(m_min);
         2: return hour_byte(m_hr, m_24);
         3: return to_bcd(m_dow);
         4: return to_bcd(m_date);
         5: return to_bcd(m_mon);
         6: return to_bcd(m_yr);
         default: return to_bcd(m_cent);
      endcase
   endfunction

   task automatic model_second();
      m_sec++;
      if (m_sec < 60) return;
      m_sec = 0; m_min++;
      if (m_min < 60) return;
      m_min = 0; m_hr++;
      if (m_hr < 24) return;
      m_hr = 0;
      m_dow = (m_dow + 1) % 7;
      m_date++;
      if (m_date <= days_of(m_mon, m_yr, m_cent)) return;
      m_date = 1; m_mon++;
      if (m_mon <= 12) return;
      m_mon = 1; m_yr++;
      if (m_yr < 100) return;
      m_yr = 0; m_cent = (m_cent + 1) % 100;
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_reg(input int a, input logic [7:0] d);
      reg_addr = 3'(a); wr_data = d; wr_en = 1'b1;
      step();
      wr_en = 1'b0;
   endtask

   task automatic load(input int s, input int mi, input int h, input bit f24,
                       input int dw, input int d, input int mo, input int y, input int c);
      m_sec = s; m_min = mi; m_hr = h; m_24 = f24; m_dow = dw;
      m_date = d; m_mon = mo; m_yr = y; m_cent = c;
      for (int a = 7; a >= 0; a--) write_reg(a, exp_byte(a));
   endtask

   task automatic pulses(input int n);
      tick_en = 1'b1;
      repeat (n) step();
      tick_en = 1'b0;
   endtask

   task automatic run_secs(input int n);
      pulses(n * DIV);
      repeat (n) model_second();
   endtask

   task automatic read_all(input string req);
      reg_addr = 3'd0; rd_start = 1'b1;
      step();
      rd_start = 1'b0;
      for (int a = 0; a < 8; a++) begin
         chk($sformatf("%s addr%0d", req, a), rd_data, exp_byte(a));
         rd_next = 1'b1; step(); rd_next = 1'b0;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7321));
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R9 reset state and cold-start halt
      m_sec = 0; m_min = 0; m_hr = 0; m_24 = 1; m_dow = 0;
      m_date = 1; m_mon = 1; m_yr = 0; m_cent = 20;
      chk("R9 halted after reset", 8'(halted), 8'd1);
      read_all("R9 reset value");
      pulses(3 * DIV);
      read_all("R9 frozen while halted");
      write_reg(3, 8'h00);
      chk("R9 halted cleared by write", 8'(halted), 8'd0);
      run_secs(1);
      read_all("R1 first second after start");

      // R1 exact tick timing: DIV-1 pulses no change
      load(10, 0, 5, 1, 1, 5, 6, 24, 20);
      pulses(DIV - 1);
      read_all("R1 no advance before DIV pulses");
      pulses(1); model_second();
      read_all("R1 advance on DIV-th pulse");

      // R10 write collides with due tick
      load(10, 0, 5, 1, 1, 5, 6, 24, 20);
      pulses(DIV - 1);
      tick_en = 1'b1; reg_addr = 3'd0; wr_data = 8'h30; wr_en = 1'b1;
      step();
      tick_en = 1'b0; wr_en = 1'b0;
      m_sec = 30;
      read_all("R10 write wins over tick");
      pulses(DIV - 1);
      read_all("R10 tick restarted after write");
      pulses(1); model_second();
      read_all("R10 full period after write");

      // R11 capture on the rollover edge
      load(59, 59, 23, 1, 6, 31, 12, 99, 20);
      pulses(DIV - 1);
      tick_en = 1'b1; reg_addr = 3'd0; rd_start = 1'b1;
      step();
      tick_en = 1'b0; rd_start = 1'b0;
      for (int a = 0; a < 8; a++) begin
         chk($sformatf("R11 held copy addr%0d", a), rd_data, exp_byte(a));
         rd_next = 1'b1; step(); rd_next = 1'b0;
      end
      model_second();
      read_all("R7 R8 new century after capture");
      reg_addr = 3'd6; rd_start = 1'b1; step(); rd_start = 1'b0;
      chk("R11 start at addr6", rd_data, exp_byte(6));
      rd_next = 1'b1; step();
      chk("R11 addr7", rd_data, exp_byte(7));
      step(); rd_next = 1'b0;
      chk("R11 pointer wraps to 0", rd_data, exp_byte(0));

      // R2 R3 minute and 24h day carry
      load(59, 59, 23, 1, 2, 14, 3, 25, 20);
      run_secs(1); read_all("R3 23:59:59 to next day");
      load(59, 41, 9, 1, 2, 14, 3, 25, 20);
      run_secs(1); read_all("R2 minute carry");

      // R4 12-hour transitions
      load(59, 59, 11, 0, 3, 10, 7, 25, 20);
      run_secs(1); read_all("R4 11AM to 12PM");
      load(59, 59, 23, 0, 3, 10, 7, 25, 20);
      run_secs(1); read_all("R4 11PM to 12AM next day");
      load(59, 59, 12, 0, 3, 10, 7, 25, 20);
      run_secs(1); read_all("R4 12PM to 1PM");
      load(59, 59, 0, 0, 3, 10, 7, 25, 20);
      run_secs(1); read_all("R4 12AM to 1AM");

      // R5 month lengths
      load(59, 59, 23, 1, 0, 30, 4, 25, 20);
      run_secs(1); read_all("R5 April 30 wraps");
      load(59, 59, 23, 1, 0, 31, 1, 25, 20);
      run_secs(1); read_all("R5 January 31 wraps");
      load(59, 59, 23, 1, 0, 30, 1, 25, 20);
      run_secs(1); read_all("R5 January 30 to 31");

      // R6 February
      load(59, 59, 23, 1, 0, 28, 2, 24, 20);
      run_secs(1); read_all("R6 leap Feb 28 to 29");
      load(59, 59, 23, 1, 0, 29, 2, 24, 20);
      run_secs(1); read_all("R6 leap Feb 29 wraps");
      load(59, 59, 23, 1, 0, 28, 2, 23, 20);
      run_secs(1); read_all("R6 common Feb 28 wraps");

      // R7 century-year rule
      load(59, 59, 23, 1, 0, 28, 2, 0, 21);
      run_secs(1); read_all("R7 year 00 century 21 not leap");
      load(59, 59, 23, 1, 0, 28, 2, 0, 20);
      run_secs(1); read_all("R7 year 00 century 20 leap");

      // R8 weekday wrap mid-month
      load(59, 59, 23, 1, 6, 9, 9, 25, 20);
      run_secs(1); read_all("R8 weekday 6 to 0");

      // constrained random near rollovers, both hour modes
      for (int it = 0; it < 40; it++) begin
         int mo, y, c, d;
         mo = 1 + int'($urandom_range(11));
         y  = ($urandom_range(3) == 0) ? 99 : int'($urandom_range(99));
         c  = 19 + int'($urandom_range(3));
         d  = days_of(mo, y, c) - int'($urandom_range(1));
         load(57 + int'($urandom_range(2)), 59 - int'($urandom_range(1)),
              ($urandom_range(1) == 0) ? 23 : int'($urandom_range(23)),
              1'($urandom_range(1)), int'($urandom_range(6)), d, mo, y, c);
         run_secs(1 + int'($urandom_range(2)));
         read_all("R1 R2 R3 R4 R5 R6 R7 R8 random rollover");
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule